// File: doc/BRIEF.md
# Register-Mapped Factorial Engine with Interrupt Status

This block is a small peripheral register file reached over a simple word-wide read/write bus. It holds a fixed identification word and a liveness word that reads back as the complement of whatever was last stored. It also holds an iterative factorial engine that runs in the background and an interrupt status word that drives a level interrupt line.

Software starts the engine by writing N to the factorial register. It then either polls the busy bit in the status register or sets the completion-interrupt enable and waits for the interrupt line. The interrupt status word can be written in two ways. A write to the raise register ORs bits in, and a write to the acknowledge register clears bits. The interrupt line stays high while any status bit is set.

Bus protocol: `bus_wr` and `bus_rd` are single-cycle strobes qualified by `bus_addr`. Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.

Top module: `fir_regblock`

## Requirements
- R1: A read of offset 0x00 returns the parameter `ID_VALUE` (default 0xC0DE0100).
- R2: A read of offset 0x04 returns the bitwise complement of the last word written there. After reset the stored word is 0, so the read gives 0xFFFFFFFF.
- R3: A write of N to offset 0x08 starts computing N!. Once the engine is idle, a read of 0x08 returns the result, for example 3628800 for N=10 and 120 for N=5.
- R4: Inputs 0 and 1 both give 1. A result that overflows is truncated to the low 32 bits, so 13 gives 1932053504.
- R5: Bit 0 of the status register at 0x20 reads 1 from the cycle after the start write until the computation ends, then reads 0.
- R6: A write to 0x08 while the engine is busy is ignored, and the running computation finishes with its original N.
- R7: Bit 7 of the status register is a writable completion-interrupt enable. If it is 1 when a computation ends, bit 0 (value 0x1) of the interrupt status register at 0x24 is set. If it is 0, the interrupt status is unchanged.
- R8: A write to offset 0x60 ORs the written word into the interrupt status register.
- R9: A write to offset 0x64 clears the interrupt status bits that are 1 in the written word. If a computation end sets bit 0 in the same cycle as an acknowledge that clears it, the set wins.
- R10: `irq_o` is 1 exactly when the interrupt status register is nonzero. It follows a raise or acknowledge write on the next clock edge.
- R11: A read of any unmapped offset (including 0x60, 0x64 and offsets from 0x80 up) returns 0. Writes to unmapped offsets change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The engine's completion event and a software acknowledge can both update the interrupt status register in the same cycle. To provoke this, the bench raises bits 0x30, enables the completion interrupt and starts N=2, which ends exactly two edges after the start write. It then places an acknowledge of all ones on that second edge. The interrupt status must then read 0x1, with the earlier bits gone, and `irq_o` must remain high; either result shows which update was given priority.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int unsigned OFF_ID    = 32'h00;
  localparam int unsigned OFF_LIVE  = 32'h04;
  localparam int unsigned OFF_FACT  = 32'h08;
  localparam int unsigned OFF_STAT  = 32'h20;
  localparam int unsigned OFF_ISTAT = 32'h24;
  localparam int unsigned OFF_RAISE = 32'h60;
  localparam int unsigned OFF_ACK   = 32'h64;

  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned IEN_BIT   = 7;
  localparam int unsigned DONE_IRQ_BIT = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LIVE,
    SEL_FACT,
    SEL_STAT,
    SEL_ISTAT,
    SEL_RAISE,
    SEL_ACK
  } reg_sel_e;
endpackage

// File: rtl/fir_fact_engine.sv
module fir_fact_engine #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] n_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] acc_q;

  // Final cycle: remaining factor is 0 or 1.
  assign done   = busy && (cnt_q <= DW'(1));
  assign result = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= n_in;
        acc_q <= DW'(1);
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      acc_q <= acc_q * cnt_q;
      cnt_q <= cnt_q - DW'(1);
    end
  end

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  assert_idle_result_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));
endmodule

// File: rtl/fir_irq_ctrl.sv
module fir_irq_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raise_we,
  input  logic          ack_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] istat,
  output logic          irq_o
);
  logic [DW-1:0] clr_mask;
  logic [DW-1:0] set_mask;
  logic [DW-1:0] istat_d;

  always_comb begin
    clr_mask = ack_we   ? wdata : '0;
    set_mask = raise_we ? wdata : '0;
    // Hardware events are applied after the clear, so they survive a same-cycle acknowledge.
    istat_d  = (istat & ~clr_mask) | set_mask | evt_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      istat <= '0;
      irq_o <= 1'b0;
    end else begin
      istat <= istat_d;
      irq_o <= |istat_d;
    end
  end

  assert_raise_sets_R8: assert property (@(posedge clk) disable iff (rst)
    raise_we |=> ((istat & $past(wdata)) == $past(wdata)));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_we && (evt_set == '0)) |=> ((istat & $past(wdata)) == '0));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((istat & $past(evt_set)) == $past(evt_set)));

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (istat != '0)));
endmodule

// File: rtl/fir_read_mux.sv
module fir_read_mux
  import fir_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] ID_VALUE = '0
) (
  input  reg_sel_e      sel,
  input  logic [DW-1:0] live_q,
  input  logic [DW-1:0] fact_res,
  input  logic          busy,
  input  logic          irq_en,
  input  logic [DW-1:0] istat,
  output logic [DW-1:0] word
);
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_BIT] = busy;
    stat_word[IEN_BIT]  = irq_en;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:    word = ID_VALUE;
      SEL_LIVE:  word = ~live_q;
      SEL_FACT:  word = fact_res;
      SEL_STAT:  word = stat_word;
      SEL_ISTAT: word = istat;
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/fir_regblock.sv
module fir_regblock
  import fir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] ID_VALUE = 32'hC0DE_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  localparam int STAT_W = IEN_BIT + 1;

  reg_sel_e      sel;
  logic [DW-1:0] live_q;
  logic          irq_en;
  logic          busy;
  logic          done;
  logic [DW-1:0] fact_res;
  logic [DW-1:0] istat;
  logic [DW-1:0] evt_set;
  logic [DW-1:0] rd_word;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_ID):    sel = SEL_ID;
      ADDR_W'(OFF_LIVE):  sel = SEL_LIVE;
      ADDR_W'(OFF_FACT):  sel = SEL_FACT;
      ADDR_W'(OFF_STAT):  sel = SEL_STAT;
      ADDR_W'(OFF_ISTAT): sel = SEL_ISTAT;
      ADDR_W'(OFF_RAISE): sel = SEL_RAISE;
      ADDR_W'(OFF_ACK):   sel = SEL_ACK;
      default:            sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      irq_en <= 1'b0;
    end else if (bus_wr) begin
      if (sel == SEL_LIVE) live_q <= bus_wdata;
      if (sel == SEL_STAT) irq_en <= bus_wdata[IEN_BIT];
    end
  end

  always_comb begin
    evt_set               = '0;
    evt_set[DONE_IRQ_BIT] = done && irq_en;
  end

  fir_fact_engine #(.DW(DW)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .start  (bus_wr && (sel == SEL_FACT)),
    .n_in   (bus_wdata),
    .busy   (busy),
    .done   (done),
    .result (fact_res)
  );

  fir_irq_ctrl #(.DW(DW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .raise_we (bus_wr && (sel == SEL_RAISE)),
    .ack_we   (bus_wr && (sel == SEL_ACK)),
    .wdata    (bus_wdata),
    .evt_set  (evt_set),
    .istat    (istat),
    .irq_o    (irq_o)
  );

  fir_read_mux #(.DW(DW), .ID_VALUE(ID_VALUE)) u_rmux (
    .sel      (sel),
    .live_q   (live_q),
    .fact_res (fact_res),
    .busy     (busy),
    .irq_en   (irq_en),
    .istat    (istat),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end

  initial begin
    assert (DW >= STAT_W) else $error("DW too narrow for status bits");
  end

  assert_live_inverse_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_LIVE)) |=> (bus_rdata == ~$past(live_q)));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_NONE)) |=> (bus_rdata == '0));

  assert_id_const_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_ID)) |=> (bus_rdata == ID_VALUE));
endmodule

// File: tb/fir_regblock_bench.sv
`timescale 1ns/1ps
module fir_regblock_bench;
  localparam int ADDR_W = 8;
  localparam int DW = 32;
  localparam logic [31:0] ID_EXP = 32'hC0DE_0100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fir_regblock #(.ADDR_W(ADDR_W), .DW(DW), .ID_VALUE(ID_EXP)) u_fir_regblock (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_read(8'h20, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] fact_ref(input int n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= n; k++) r = r * 32'(k);
    return r;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    check("R10 reset irq", {31'b0, irq_o}, 32'h0);
    bus_read(8'h00, d); check("R1 id", d, ID_EXP);
    bus_read(8'h04, d); check("R2 live after reset", d, 32'hFFFF_FFFF);
    bus_read(8'h20, d); check("R5 status after reset", d, 32'h0);
    bus_read(8'h24, d); check("R9 istat after reset", d, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    bus_write(8'h04, 32'hDEAD_BEEF);
    bus_read(8'h04, d); check("R2 live complement", d, 32'h2152_4110);
    bus_write(8'h04, 32'h0000_00FF);
    bus_read(8'h04, d); check("R2 live second", d, 32'hFFFF_FF00);
  endtask

  task automatic t_factorials();
    logic [31:0] d;
    int vals[6] = '{10, 5, 0, 1, 12, 13};
    foreach (vals[i]) begin
      bus_write(8'h08, 32'(vals[i]));
      wait_idle();
      bus_read(8'h08, d);
      if (vals[i] <= 1 || vals[i] == 13) check("R4 factorial edge", d, fact_ref(vals[i]));
      else check("R3 factorial", d, fact_ref(vals[i]));
    end
    check("R4 overflow constant", fact_ref(13), 32'd1932053504);
  endtask

  task automatic t_busy_and_ignore();
    logic [31:0] d;
    bus_write(8'h08, 32'd10);
    bus_read(8'h20, d); check("R5 busy set", {31'b0, d[0]}, 32'h1);
    bus_write(8'h08, 32'd3);
    wait_idle();
    bus_read(8'h20, d); check("R5 busy cleared", {31'b0, d[0]}, 32'h0);
    bus_read(8'h08, d); check("R6 write while busy ignored", d, 32'd3628800);
  endtask

  task automatic t_irq_completion();
    logic [31:0] d;
    bus_write(8'h20, 32'h0);
    bus_write(8'h08, 32'd4);
    wait_idle();
    bus_read(8'h24, d); check("R7 no irq when disabled", d, 32'h0);
    check("R7 irq line low when disabled", {31'b0, irq_o}, 32'h0);
    bus_write(8'h20, 32'h80);
    bus_read(8'h20, d); check("R7 enable readback", d, 32'h80);
    bus_write(8'h08, 32'd5);
    wait_idle();
    bus_read(8'h24, d); check("R7 completion irq bit", d, 32'h1);
    bus_read(8'h08, d); check("R3 result 5", d, 32'd120);
    check("R10 irq high", {31'b0, irq_o}, 32'h1);
    bus_write(8'h64, 32'hFFFF_FFFF);
    check("R10 irq low after ack", {31'b0, irq_o}, 32'h0);
    bus_write(8'h20, 32'h0);
  endtask

  task automatic t_raise_ack();
    logic [31:0] d;
    bus_write(8'h60, 32'h0000_0500);
    check("R10 irq follows raise", {31'b0, irq_o}, 32'h1);
    bus_write(8'h60, 32'h8000_0002);
    bus_read(8'h24, d); check("R8 raise OR", d, 32'h8000_0502);
    bus_write(8'h64, 32'h0000_0402);
    bus_read(8'h24, d); check("R9 partial ack", d, 32'h8000_0100);
    check("R10 irq still high", {31'b0, irq_o}, 32'h1);
    bus_write(8'h64, 32'hFFFF_FFFF);
    bus_read(8'h24, d); check("R9 ack all", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    bus_write(8'h20, 32'h80);
    bus_write(8'h60, 32'h30);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd2;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(8'h24, d); check("R9 completion wins over ack", d, 32'h1);
    check("R10 irq after collision", {31'b0, irq_o}, 32'h1);
    bus_write(8'h64, 32'hFFFF_FFFF);
    bus_write(8'h20, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(8'h60, d); check("R11 raise reads zero", d, 32'h0);
    bus_read(8'h64, d); check("R11 ack reads zero", d, 32'h0);
    bus_read(8'h88, d); check("R11 high offset zero", d, 32'h0);
    bus_read(8'h05, d); check("R11 misaligned zero", d, 32'h0);
    bus_write(8'h0C, 32'h1234_5678);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read(8'h04, d); check("R11 live untouched", d, 32'hFFFF_FF00);
    bus_read(8'h24, d); check("R11 istat not writable", d, 32'h0);
    bus_read(8'h08, d); check("R11 fact untouched", d, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_live();
    t_factorials();
    t_busy_and_ignore();
    t_irq_completion();
    t_raise_ack();
    t_collision();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule